// File: doc/BRIEF.md
# Debug-State Data Abort Tracker

This block records data aborts that reach a processor core while it is halted for debugging. Aborts that the debugger causes are reported as sticky status and are otherwise harmless. A synchronous abort sets its own sticky bit and loads the fault status and fault address registers with the values the core supplies. An asynchronous abort sets a separate sticky bit whatever the core's abort mask says. It never touches the fault registers.

The block separates asynchronous aborts that belong to the program from those the debugger causes. When the core enters debug state, a barrier drains outstanding memory traffic. Any asynchronous abort that shows up before that barrier completes is held as pending and handed back to the core after debug exit, once the core's abort mask allows it. Asynchronous aborts that arrive after the barrier has completed are counted as debugger-made. They are dropped when the core leaves debug state.

Top module: `dbg_abort_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the status word, fault status, fault address, pending flag and delivery strobe are all zero.
- R2: A synchronous abort sampled while in debug state sets bit 6 of the status word from the next cycle.
- R3: A synchronous abort sampled in any state loads faultStatus and faultAddr from the fault inputs in the next cycle. Without one, both registers hold their value.
- R4: An asynchronous abort sampled while in debug state sets bit 7 of the status word from the next cycle, for either value of the abort mask.
- R5: An asynchronous abort on its own never changes faultStatus or faultAddr.
- R6: An asynchronous abort sampled in debug state, before barrierDone has been seen or in the same cycle as barrierDone, sets abortPending from the next cycle.
- R7: An asynchronous abort sampled after barrierDone in the same debug visit does not set abortPending.
- R8: Bits 6 and 7 stay set until stickyClear is sampled. If stickyClear and a new abort of the same kind are sampled in the same cycle, the bit stays set.
- R9: abortTake is high exactly when abortPending is set, the core is out of debug state and abortMask is 0. abortPending clears in the cycle after abortTake. Until then it holds, including while masked or in debug state.
- R10: Aborts sampled outside debug state never set bits 6 or 7. All status word bits other than 6 and 7 always read zero.
- R11: The barrier phase starts again on every entry to debug state, so an asynchronous abort before the next barrierDone is held again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inDebug | input | 1 | Core is halted in debug state |
| syncAbort | input | 1 | Synchronous data abort strobe |
| asyncAbort | input | 1 | Asynchronous data abort strobe |
| barrierDone | input | 1 | Entry barrier completed strobe |
| faultStatusIn | input | FS_W | Fault status of the synchronous abort |
| faultAddrIn | input | ADDR_W | Fault address of the synchronous abort |
| abortMask | input | 1 | Core asynchronous abort mask, 1 = masked |
| stickyClear | input | 1 | Clears the sticky abort bits |
| statusWord | output | 32 | Debug status word: bit 6 synchronous sticky, bit 7 asynchronous sticky |
| faultStatus | output | FS_W | Fault status register |
| faultAddr | output | ADDR_W | Fault address register |
| abortPending | output | 1 | Entry-time asynchronous abort held for delivery |
| abortTake | output | 1 | One-cycle delivery of the pending abort to the core |

## Verification
The hardest state to reach is a held abort that outlives its debug visit. The bench has to raise an asynchronous abort in the short stretch between debug entry and barrierDone, and the same cycle as barrierDone counts as part of that stretch. It then has to leave debug state with the mask still set, so that delivery waits. The directed sequence sets up that window on purpose, clears the mask several cycles after exit, and then re-enters debug state to show that the window opens again. A long random phase toggles debug state and mask at a low rate, so that entries, barriers and exits interleave with held aborts many times over.

// File: rtl/dbg_abort_pkg.sv
package dbg_abort_pkg;
  localparam int STATUS_W = 32;
  localparam int SYNC_STICKY_BIT = 6;
  localparam int ASYNC_STICKY_BIT = 7;
  localparam int STICKY_N = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic setSync;
    logic setAsync;
    logic clrSticky;
    logic loadFault;
    logic setPend;
    logic dropPend;
  } abort_ctl_t;
endpackage

// File: rtl/dbg_abort_ctl.sv
module dbg_abort_ctl
  import dbg_abort_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inDebug,
  input  logic       syncAbort,
  input  logic       asyncAbort,
  input  logic       barrierDone,
  input  logic       abortMask,
  input  logic       stickyClear,
  input  logic       pendHeld,
  output abort_ctl_t ctl,
  output logic       abortTake
);
  logic barrierSeen;
  logic entryWindow;

  // Barrier phase: re-armed whenever the core is out of debug state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              barrierSeen <= 1'b0;
    else if (!inDebug)      barrierSeen <= 1'b0;
    else if (barrierDone)   barrierSeen <= 1'b1;
  end

  assign entryWindow = inDebug & ~barrierSeen;
  assign abortTake   = pendHeld & ~inDebug & ~abortMask;

  always_comb begin
    ctl           = '0;
    ctl.setSync   = syncAbort & inDebug;
    ctl.setAsync  = asyncAbort & inDebug;
    ctl.clrSticky = stickyClear;
    ctl.loadFault = syncAbort;
    ctl.setPend   = asyncAbort & entryWindow;
    ctl.dropPend  = abortTake;
  end
endmodule

// File: rtl/dbg_abort_dp.sv
module dbg_abort_dp
  import dbg_abort_pkg::*;
#(
  parameter int FS_W   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  abort_ctl_t          ctl,
  input  logic [FS_W-1:0]     faultStatusIn,
  input  logic [ADDR_W-1:0]   faultAddrIn,
  output logic [STATUS_W-1:0] statusWord,
  output logic [FS_W-1:0]     faultStatus,
  output logic [ADDR_W-1:0]   faultAddr,
  output logic                pendHeld
);
  logic [STICKY_N-1:0] stickySet;
  logic [STICKY_N-1:0] stickyQ;

  assign stickySet = {ctl.setAsync, ctl.setSync};

  // Sticky bits: a set in the same cycle overrides a clear
  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              stickyQ[i] <= 1'b0;
      else if (stickySet[i])  stickyQ[i] <= 1'b1;
      else if (ctl.clrSticky) stickyQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultStatus <= '0;
      faultAddr   <= '0;
    end else if (ctl.loadFault) begin
      faultStatus <= faultStatusIn;
      faultAddr   <= faultAddrIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendHeld <= 1'b0;
    else if (ctl.setPend)  pendHeld <= 1'b1;
    else if (ctl.dropPend) pendHeld <= 1'b0;
  end

  always_comb begin
    statusWord                   = '0;
    statusWord[SYNC_STICKY_BIT]  = stickyQ[0];
    statusWord[ASYNC_STICKY_BIT] = stickyQ[1];
  end
endmodule

// File: rtl/dbg_abort_tracker.sv
module dbg_abort_tracker
  import dbg_abort_pkg::*;
#(
  parameter int FS_W   = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inDebug,
  input  logic              syncAbort,
  input  logic              asyncAbort,
  input  logic              barrierDone,
  input  logic [FS_W-1:0]   faultStatusIn,
  input  logic [ADDR_W-1:0] faultAddrIn,
  input  logic              abortMask,
  input  logic              stickyClear,
  output logic [31:0]       statusWord,
  output logic [FS_W-1:0]   faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              abortPending,
  output logic              abortTake
);
  abort_ctl_t ctl;
  logic       pendHeld;

  dbg_abort_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inDebug(inDebug), .syncAbort(syncAbort),
    .asyncAbort(asyncAbort), .barrierDone(barrierDone), .abortMask(abortMask),
    .stickyClear(stickyClear), .pendHeld(pendHeld), .ctl(ctl), .abortTake(abortTake)
  );

  dbg_abort_dp #(.FS_W(FS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .faultStatusIn(faultStatusIn),
    .faultAddrIn(faultAddrIn), .statusWord(statusWord), .faultStatus(faultStatus),
    .faultAddr(faultAddr), .pendHeld(pendHeld)
  );

  assign abortPending = pendHeld;
endmodule

// File: rtl/dbg_abort_checker.sv
module dbg_abort_checker #(
  parameter int FS_W   = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inDebug,
  input logic              syncAbort,
  input logic              asyncAbort,
  input logic [FS_W-1:0]   faultStatusIn,
  input logic [ADDR_W-1:0] faultAddrIn,
  input logic              stickyClear,
  input logic [31:0]       statusWord,
  input logic [FS_W-1:0]   faultStatus,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              abortPending,
  input logic              abortTake
);
  assert_sync_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    inDebug && syncAbort |=> statusWord[6]);

  assert_fault_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    syncAbort |=> faultAddr == $past(faultAddrIn) && faultStatus == $past(faultStatusIn));

  assert_async_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    inDebug && asyncAbort |=> statusWord[7]);

  assert_async_no_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    asyncAbort && !syncAbort |=> $stable(faultStatus) && $stable(faultAddr));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[7] && !stickyClear |=> statusWord[7]);

  assert_pend_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortTake |=> !abortPending);

  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortPending && !abortTake |=> abortPending);

  assert_status_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & 32'hFFFF_FF3F) == 32'h0);
endmodule

bind dbg_abort_tracker dbg_abort_checker #(.FS_W(FS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inDebug(inDebug), .syncAbort(syncAbort),
  .asyncAbort(asyncAbort), .faultStatusIn(faultStatusIn), .faultAddrIn(faultAddrIn),
  .stickyClear(stickyClear), .statusWord(statusWord), .faultStatus(faultStatus),
  .faultAddr(faultAddr), .abortPending(abortPending), .abortTake(abortTake)
);

// File: tb/tb_dbg_abort_tracker.sv
module tb_dbg_abort_tracker;
  localparam int FS_W = 16;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inDebug = 0, syncAbort = 0, asyncAbort = 0, barrierDone = 0;
  logic abortMask = 0, stickyClear = 0;
  logic [FS_W-1:0] faultStatusIn = '0;
  logic [ADDR_W-1:0] faultAddrIn = '0;
  logic [31:0] statusWord;
  logic [FS_W-1:0] faultStatus;
  logic [ADDR_W-1:0] faultAddr;
  logic abortPending, abortTake;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  bit mSync = 0, mAsync = 0, mBar = 0, mPend = 0;
  logic [FS_W-1:0] mFs = '0;
  logic [ADDR_W-1:0] mFa = '0;

  always #10 clk = ~clk;

  dbg_abort_tracker #(.FS_W(FS_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .inDebug(inDebug), .syncAbort(syncAbort),
    .asyncAbort(asyncAbort), .barrierDone(barrierDone), .faultStatusIn(faultStatusIn),
    .faultAddrIn(faultAddrIn), .abortMask(abortMask), .stickyClear(stickyClear),
    .statusWord(statusWord), .faultStatus(faultStatus), .faultAddr(faultAddr),
    .abortPending(abortPending), .abortTake(abortTake)
  );

  task automatic chk32(string tag, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare now, then advance the model across the next rising edge
  task automatic tick(string tag);
    bit take;
    bit window;
    logic [31:0] expStatus;
    #2;
    take = mPend && !inDebug && !abortMask;
    expStatus = 32'h0;
    expStatus[6] = mSync;
    expStatus[7] = mAsync;
    vectors++;
    chk32(tag, "statusWord", 64'(statusWord), 64'(expStatus));
    chk32(tag, "faultStatus", 64'(faultStatus), 64'(mFs));
    chk32(tag, "faultAddr", 64'(faultAddr), 64'(mFa));
    chk32(tag, "abortPending", 64'(abortPending), 64'(mPend));
    chk32(tag, "abortTake", 64'(abortTake), 64'(take));
    @(posedge clk);
    if (!rstN) begin
      mSync = 0; mAsync = 0; mBar = 0; mPend = 0; mFs = '0; mFa = '0;
    end else begin
      window = inDebug && !mBar;
      if (!inDebug) mBar = 0;
      else if (barrierDone) mBar = 1;
      if (take) mPend = 0;
      if (asyncAbort && window) mPend = 1;
      mSync  = (syncAbort && inDebug) || (mSync && !stickyClear);
      mAsync = (asyncAbort && inDebug) || (mAsync && !stickyClear);
      if (syncAbort) begin mFs = faultStatusIn; mFa = faultAddrIn; end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    syncAbort = 0; asyncAbort = 0; barrierDone = 0; stickyClear = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick("R1");   // reset values
    rstN = 1;
    tick("R1");

    // outside debug: fault load, no sticky bits
    syncAbort = 1; faultStatusIn = 16'h0012; faultAddrIn = 32'h0000_1000;
    tick("R3");
    idle(); faultStatusIn = 16'hFFFF; faultAddrIn = 32'hDEAD_BEEF;
    tick("R10");
    tick("R3");
    asyncAbort = 1;
    tick("R5");
    idle();
    tick("R10");

    // entry window, masked: held abort
    inDebug = 1; abortMask = 1; asyncAbort = 1;
    tick("R6");
    idle();
    tick("R4");
    barrierDone = 1;
    tick("R7");
    idle(); abortMask = 0; asyncAbort = 1;
    tick("R7");
    idle();
    tick("R4");

    // synchronous abort in debug
    syncAbort = 1; faultStatusIn = 16'h0003; faultAddrIn = 32'h0000_ABCD;
    tick("R2");
    idle();
    tick("R3");

    // sticky clear vs set
    stickyClear = 1; asyncAbort = 1;
    tick("R8");
    idle();
    tick("R8");
    stickyClear = 1;
    tick("R8");
    idle();
    tick("R8");

    // exit masked, delivery after unmask
    abortMask = 1; inDebug = 0;
    tick("R9");
    tick("R9");
    tick("R9");
    abortMask = 0;
    tick("R9");
    tick("R9");

    // re-entry opens the window again; async at barrier cycle is held
    inDebug = 1; abortMask = 0;
    tick("R11");
    asyncAbort = 1; barrierDone = 1;
    tick("R6");
    idle();
    tick("R11");
    asyncAbort = 1;
    tick("R7");
    idle();
    tick("R11");
    inDebug = 0;
    tick("R9");
    tick("R9");
    inDebug = 1;
    tick("R11");
    asyncAbort = 1;
    tick("R11");
    idle(); inDebug = 0;
    tick("R11");
    tick("R11");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) inDebug = ~inDebug;
      if ($urandom_range(0, 15) == 0) abortMask = ~abortMask;
      barrierDone = ($urandom_range(0, 7) == 0);
      syncAbort   = ($urandom_range(0, 9) == 0);
      asyncAbort  = ($urandom_range(0, 9) == 0);
      stickyClear = ($urandom_range(0, 19) == 0);
      faultStatusIn = FS_W'($urandom);
      faultAddrIn   = ADDR_W'($urandom);
      tick("RND");
    end
    idle();
    tick("RND");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule